// File: doc/BRIEF.md
# Eight-Channel Periodic Down-Counter Bank

The block holds eight independent 32-bit down-counters behind a word-addressed 32-bit register port, with one interrupt level per channel. Once enabled, a channel counts down from its reload value, reaches zero, reloads and carries on, so it runs periodically. Every channel advances either on each bus clock cycle or on a single-cycle external 1 MHz strobe, chosen per channel.

Each channel compares its count against two match values and inverts its interrupt level whenever a watched event occurs, so software acknowledges by noting the level change rather than clearing a flag. One shared control word holds four bits per channel. Channels 0 to 2 sit below the control word in the address map and channels 3 to 7 sit above it.

Top module: `tmr_bank`

## Requirements
- R1: The port takes word addresses. Word address bits [5:2] select a 16-byte slot and bits [1:0] select a register: 0 live count, 1 reload, 2 first match, 3 second match. Slots 0 to 2 are channels 0 to 2; slots 4 to 8 are channels 3 to 7 (slot minus one).
- R2: Slot 3, register 0 is the control word: channel n uses bits [4n+3:4n], with bit 0 enable, bit 1 external-strobe select, bit 2 zero-interrupt enable, bit 3 pulse flag. Slot 3, register 1 is a spare word. Both read back what was last written.
- R3: Slot 3 registers 2 and 3, slots 9 to 15, and any address with a nonzero bit above bit 5 read as zero; writes there change no register.
- R4: After reset every count, reload, match value, both control words and all interrupt levels are zero.
- R5: While a channel is disabled its count reads as the reload value and a write to its count register is ignored.
- R6: An enable bit changing from 0 to 1 loads the count from the reload value; changing from 1 to 0 freezes the channel, and its interrupt level no longer changes.
- R7: With the select bit clear a running channel decrements once per bus clock; with it set it decrements only in cycles where the external strobe is high.
- R8: A running channel whose count is zero loads the reload value on its next decrement step, so the period is reload plus one steps.
- R9: When a decrement produces a nonzero value equal to either effective match value, the channel's interrupt level inverts. A match value greater than or equal to the reload value counts as zero.
- R10: When a decrement produces zero, the level inverts only if the zero-interrupt bit is set or either effective match value is zero; at most one inversion occurs per step.
- R11: A count write to an enabled channel loads the written value and takes precedence over a decrement in the same cycle.
- R12: The pulse flag is stored on every channel and changes neither counting nor interrupts.
- R13: Read data appears one cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| ext_tick | input | 1 | Single-cycle external 1 MHz step strobe, synchronous to clk |
| bus_req | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_waddr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 8 | Interrupt level, one bit per channel |

## Verification
Two actions can land in the same cycle. The first pair is a software count write and a decrement step: the bench raises the external strobe in the very cycle of the write and expects the written value to read back, not that value minus one. The second pair is a zero event and a match event on a match value at or above the reload value, which counts as zero. The bench runs such a channel to zero with its level high and expects exactly one inversion, so the level ends low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Control bits per channel and their positions inside a channel field
  localparam int unsigned CB     = 4;
  localparam int unsigned CB_EN  = 0;
  localparam int unsigned CB_EXT = 1;
  localparam int unsigned CB_OVF = 2;

  // Register index inside a 16-byte channel slot
  typedef enum logic [1:0] {
    RG_CNT = 2'd0,
    RG_RLD = 2'd1,
    RG_M0  = 2'd2,
    RG_M1  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ext_sel,
  input  logic          ovf_en,
  input  logic          ext_tick,
  input  logic          en_rise,
  input  logic          wr_cnt,
  input  logic          wr_rld,
  input  logic          wr_m0,
  input  logic          wr_m1,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt_view,
  output logic [DW-1:0] rld_q,
  output logic [DW-1:0] m0_q,
  output logic [DW-1:0] m1_q,
  output logic          irq_q
);
  logic [DW-1:0] cnt_q, cnt_d, dec_val, m0_eff, m1_eff;
  logic          irq_d, tick_ok, step, zero_evt, hit;

  // Effective match values: out-of-range settings act as zero
  always_comb begin
    m0_eff   = (m0_q < rld_q) ? m0_q : '0;
    m1_eff   = (m1_q < rld_q) ? m1_q : '0;
    tick_ok  = ext_sel ? ext_tick : 1'b1;
    step     = en && tick_ok && !wr_cnt;
    dec_val  = cnt_q - DW'(1);
    zero_evt = ovf_en || (m0_eff == '0) || (m1_eff == '0);
    hit      = (dec_val == '0) ? zero_evt
                               : ((dec_val == m0_eff) || (dec_val == m1_eff));
  end

  // Next state of count and interrupt level
  always_comb begin
    cnt_d = cnt_q;
    irq_d = irq_q;
    if (en_rise) begin
      cnt_d = rld_q;
    end else if (en && wr_cnt) begin
      cnt_d = wdata;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_d = rld_q;
      end else begin
        cnt_d = dec_val;
        if (hit) irq_d = !irq_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rld_q <= '0;
    else if (wr_rld) rld_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     m0_q <= '0;
    else if (wr_m0) m0_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     m1_q <= '0;
    else if (wr_m1) m1_q <= wdata;
  end

  assign cnt_view = en ? cnt_q : rld_q;

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !en_rise) |=> $stable(cnt_q)); // R6
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (cnt_q == $past(rld_q))); // R6
  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_cnt) |=> (cnt_q == $past(wdata))); // R11
  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick_ok && !wr_cnt && (cnt_q == '0)) |=> (cnt_q == $past(rld_q))); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && tick_ok) |=> $stable(irq_q)); // R9
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 10,
  parameter int unsigned LO_CH = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_req,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_waddr,
  input  logic [DW-1:0]          bus_wdata,
  input  logic [NCH-1:0][DW-1:0] cnt_view,
  input  logic [NCH-1:0][DW-1:0] rld_q,
  input  logic [NCH-1:0][DW-1:0] m0_q,
  input  logic [NCH-1:0][DW-1:0] m1_q,
  output logic [NCH-1:0]         wr_cnt,
  output logic [NCH-1:0]         wr_rld,
  output logic [NCH-1:0]         wr_m0,
  output logic [NCH-1:0]         wr_m1,
  output logic [NCH-1:0]         en_rise,
  output logic [NCH-1:0]         ch_en,
  output logic [NCH-1:0]         ch_ext,
  output logic [NCH-1:0]         ch_ovf,
  output logic [DW-1:0]          bus_rdata
);
  localparam int unsigned CH_W      = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [3:0]  CTRL_SLOT = 4'(LO_CH);
  localparam logic [3:0]  LAST_SLOT = 4'(NCH);

  logic [3:0]      slot;
  reg_sel_e        rsel;
  logic            in_page, hit_ch, hit_ctrl, hit_ctrl2, hit_any;
  logic [CH_W-1:0] ch_idx;
  logic            wr_stb, rd_stb, ctrl_wr, ctrl2_wr;
  logic [DW-1:0]   ctrl_q, ctrl_d, ctrl2_q, ctrl2_d, rd_d, rdata_q;

  // Address decode: two channel windows around the control slot
  always_comb begin
    slot      = bus_waddr[5:2];
    rsel      = reg_sel_e'(bus_waddr[1:0]);
    in_page   = (bus_waddr[AW-1:6] == '0);
    hit_ch    = 1'b0;
    hit_ctrl  = 1'b0;
    hit_ctrl2 = 1'b0;
    ch_idx    = '0;
    if (in_page) begin
      if (slot < CTRL_SLOT) begin
        hit_ch = 1'b1;
        ch_idx = CH_W'(slot);
      end else if (slot == CTRL_SLOT) begin
        hit_ctrl  = (rsel == RG_CNT);
        hit_ctrl2 = (rsel == RG_RLD);
      end else if (slot <= LAST_SLOT) begin
        hit_ch = 1'b1;
        ch_idx = CH_W'(slot - 4'd1);
      end
    end
    hit_any = hit_ch || hit_ctrl || hit_ctrl2;
  end

  assign wr_stb   = bus_req && bus_we;
  assign rd_stb   = bus_req && !bus_we;
  assign ctrl_wr  = wr_stb && hit_ctrl;
  assign ctrl2_wr = wr_stb && hit_ctrl2;

  // Per-channel strobes and control fields
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      wr_cnt[c]  = wr_stb && hit_ch && (ch_idx == CH_W'(c)) && (rsel == RG_CNT);
      wr_rld[c]  = wr_stb && hit_ch && (ch_idx == CH_W'(c)) && (rsel == RG_RLD);
      wr_m0[c]   = wr_stb && hit_ch && (ch_idx == CH_W'(c)) && (rsel == RG_M0);
      wr_m1[c]   = wr_stb && hit_ch && (ch_idx == CH_W'(c)) && (rsel == RG_M1);
      en_rise[c] = ctrl_wr && !ctrl_q[c*CB+CB_EN] && bus_wdata[c*CB+CB_EN];
      ch_en[c]   = ctrl_q[c*CB+CB_EN];
      ch_ext[c]  = ctrl_q[c*CB+CB_EXT];
      ch_ovf[c]  = ctrl_q[c*CB+CB_OVF];
    end
  end

  always_comb begin
    ctrl_d  = ctrl_wr  ? bus_wdata : ctrl_q;
    ctrl2_d = ctrl2_wr ? bus_wdata : ctrl2_q;
  end

  // Read multiplexer
  always_comb begin
    rd_d = '0;
    if (hit_ch) begin
      case (rsel)
        RG_CNT:  rd_d = cnt_view[ch_idx];
        RG_RLD:  rd_d = rld_q[ch_idx];
        RG_M0:   rd_d = m0_q[ch_idx];
        default: rd_d = m1_q[ch_idx];
      endcase
    end else if (hit_ctrl) begin
      rd_d = ctrl_q;
    end else if (hit_ctrl2) begin
      rd_d = ctrl2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ctrl2_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      ctrl2_q <= ctrl2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_stb) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_cnt, wr_rld, wr_m0, wr_m1, ctrl_wr, ctrl2_wr})); // R1
  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && hit_ctrl) |=> (bus_rdata == $past(ctrl_q))); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !hit_any) |=> (bus_rdata == '0)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(bus_rdata)); // R13
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 10,
  parameter int unsigned LO_CH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ext_tick,
  input  logic           bus_req,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_waddr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq
);
  logic                   rst_n_s;
  logic [NCH-1:0][DW-1:0] cnt_view, rld_q, m0_q, m1_q;
  logic [NCH-1:0]         wr_cnt, wr_rld, wr_m0, wr_m1, en_rise;
  logic [NCH-1:0]         ch_en, ch_ext, ch_ovf;

  tmr_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  tmr_regif #(
    .NCH   (NCH),
    .DW    (DW),
    .AW    (AW),
    .LO_CH (LO_CH)
  ) i_regif (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_waddr (bus_waddr),
    .bus_wdata (bus_wdata),
    .cnt_view  (cnt_view),
    .rld_q     (rld_q),
    .m0_q      (m0_q),
    .m1_q      (m1_q),
    .wr_cnt    (wr_cnt),
    .wr_rld    (wr_rld),
    .wr_m0     (wr_m0),
    .wr_m1     (wr_m1),
    .en_rise   (en_rise),
    .ch_en     (ch_en),
    .ch_ext    (ch_ext),
    .ch_ovf    (ch_ovf),
    .bus_rdata (bus_rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    tmr_chan #(.DW(DW)) i_chan (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .en       (ch_en[c]),
      .ext_sel  (ch_ext[c]),
      .ovf_en   (ch_ovf[c]),
      .ext_tick (ext_tick),
      .en_rise  (en_rise[c]),
      .wr_cnt   (wr_cnt[c]),
      .wr_rld   (wr_rld[c]),
      .wr_m0    (wr_m0[c]),
      .wr_m1    (wr_m1[c]),
      .wdata    (bus_wdata),
      .cnt_view (cnt_view[c]),
      .rld_q    (rld_q[c]),
      .m0_q     (m0_q[c]),
      .m1_q     (m1_q[c]),
      .irq_q    (irq[c])
    );
  end
endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NV         = 29;

  // {write, byte offset, data, expected read}
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h004, 32'h0000_0011, 32'h0},
    {1'b1, 12'h018, 32'h0000_0022, 32'h0},
    {1'b1, 12'h02C, 32'h0000_0033, 32'h0},
    {1'b1, 12'h044, 32'h0000_0044, 32'h0},
    {1'b1, 12'h08C, 32'h0000_0055, 32'h0},
    {1'b1, 12'h078, 32'h0000_0066, 32'h0},
    {1'b0, 12'h004, 32'h0, 32'h0000_0011},
    {1'b0, 12'h018, 32'h0, 32'h0000_0022},
    {1'b0, 12'h02C, 32'h0, 32'h0000_0033},
    {1'b0, 12'h044, 32'h0, 32'h0000_0044},
    {1'b0, 12'h08C, 32'h0, 32'h0000_0055},
    {1'b0, 12'h078, 32'h0, 32'h0000_0066},
    {1'b0, 12'h000, 32'h0, 32'h0000_0011},
    {1'b0, 12'h040, 32'h0, 32'h0000_0044},
    {1'b1, 12'h030, 32'h8888_8888, 32'h0},
    {1'b0, 12'h030, 32'h0, 32'h8888_8888},
    {1'b1, 12'h034, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 12'h034, 32'h0, 32'hDEAD_BEEF},
    {1'b1, 12'h038, 32'h0000_1234, 32'h0},
    {1'b0, 12'h038, 32'h0, 32'h0},
    {1'b0, 12'h03C, 32'h0, 32'h0},
    {1'b1, 12'h090, 32'h0000_0099, 32'h0},
    {1'b0, 12'h090, 32'h0, 32'h0},
    {1'b1, 12'h104, 32'h0000_00AB, 32'h0},
    {1'b0, 12'h104, 32'h0, 32'h0},
    {1'b0, 12'h004, 32'h0, 32'h0000_0011},
    {1'b0, 12'h084, 32'h0, 32'h0},
    {1'b1, 12'h030, 32'h0, 32'h0},
    {1'b0, 12'h030, 32'h0, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n, ext_tick, bus_req, bus_we;
  logic [9:0]  bus_waddr;
  logic [31:0] bus_wdata, bus_rdata, rd;
  logic [7:0]  irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_bank i_tmr_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_tick  (ext_tick),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_waddr (bus_waddr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_waddr = a[11:2]; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_waddr = a[11:2];
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      ext_tick = 1'b1;
      @(negedge clk);
      ext_tick = 1'b0;
    end
  endtask

  function automatic string tag_of(input logic [11:0] a);
    if (a == 12'h030 || a == 12'h034) return "R2 ctrl word";
    if (a[11:8] != 4'h0 || a == 12'h038 || a == 12'h03C || a >= 12'h090) return "R3 unmapped";
    return "R1 channel map";
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_tick = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    bus_waddr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 reset state
    chk("R4 irq after reset", {24'h0, irq}, 32'h0);
    bus_rd(12'h030, rd); chk("R4 ctrl after reset", rd, 32'h0);
    bus_rd(12'h004, rd); chk("R4 reload after reset", rd, 32'h0);

    // Register map vectors
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) bus_wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        bus_rd(VEC[i][75:64], rd);
        chk(tag_of(VEC[i][75:64]), rd, VEC[i][31:0]);
      end
    end

    // R13 read data holds across a write
    bus_rd(12'h004, rd); chk("R13 read value", rd, 32'h11);
    bus_wr(12'h008, 32'h5);
    chk("R13 rdata holds", bus_rdata, 32'h11);

    // R7 bus clock rate on channel 2, then external strobe
    bus_wr(12'h024, 32'd1000);
    bus_wr(12'h030, 32'h0000_0100);
    bus_rd(12'h020, rd); chk("R7 first bus-clock read", rd, 32'd1000);
    bus_rd(12'h020, rd); chk("R7 next bus-clock read", rd, 32'd999);
    bus_wr(12'h030, 32'h0000_0300);
    bus_rd(12'h020, rd); chk("R7 strobe mode holds", rd, 32'd997);
    bus_rd(12'h020, rd); chk("R7 strobe mode holds again", rd, 32'd997);
    tick(1);
    bus_rd(12'h020, rd); chk("R7 one strobe one step", rd, 32'd996);
    bus_wr(12'h030, 32'h0);

    // R9 R10 R8 on channel 0: reload 10, matches 6 and 3
    bus_wr(12'h004, 32'd10);
    bus_wr(12'h008, 32'd6);
    bus_wr(12'h00C, 32'd3);
    bus_wr(12'h030, 32'h3);
    tick(3); chk("R9 no toggle before match", {31'h0, irq[0]}, 32'd0);
    tick(1); chk("R9 toggle at first match", {31'h0, irq[0]}, 32'd1);
    tick(3); chk("R9 toggle at second match", {31'h0, irq[0]}, 32'd0);
    tick(3); chk("R10 zero without zero-irq bit", {31'h0, irq[0]}, 32'd0);
    bus_rd(12'h000, rd); chk("R8 count at zero", rd, 32'd0);
    tick(1);
    bus_rd(12'h000, rd); chk("R8 reload after zero", rd, 32'd10);
    bus_wr(12'h030, 32'h7);
    tick(10); chk("R10 zero with zero-irq bit", {31'h0, irq[0]}, 32'd1);

    // R6 R5 disable, ignored count write, re-enable
    bus_wr(12'h030, 32'h0);
    tick(20); chk("R6 level frozen when stopped", {31'h0, irq[0]}, 32'd1);
    bus_rd(12'h000, rd); chk("R5 disabled count reads reload", rd, 32'd10);
    bus_wr(12'h000, 32'd4);
    bus_rd(12'h000, rd); chk("R5 disabled count write ignored", rd, 32'd10);
    bus_wr(12'h030, 32'h3);
    bus_rd(12'h000, rd); chk("R6 enable loads reload", rd, 32'd10);
    bus_wr(12'h030, 32'h0);

    // R12 pulse flag has no effect
    bus_wr(12'h030, 32'hB);
    tick(4);
    chk("R12 irq with pulse flag", {31'h0, irq[0]}, 32'd0);
    bus_rd(12'h000, rd); chk("R12 count with pulse flag", rd, 32'd6);
    bus_rd(12'h030, rd); chk("R12 pulse flag stored", rd, 32'hB);
    bus_wr(12'h030, 32'h0);

    // R9 R10 channel 4: match at or above reload acts as zero
    bus_wr(12'h054, 32'd5);
    bus_wr(12'h058, 32'd9);
    bus_wr(12'h05C, 32'd2);
    bus_wr(12'h030, 32'h0003_0000);
    tick(3); chk("R9 ch4 toggle at match 2", {31'h0, irq[4]}, 32'd1);
    tick(1); chk("R9 ch4 no toggle at 1", {31'h0, irq[4]}, 32'd1);
    tick(1); chk("R10 ch4 single toggle at zero", {31'h0, irq[4]}, 32'd0);
    bus_rd(12'h050, rd); chk("R10 ch4 count zero", rd, 32'd0);
    bus_wr(12'h030, 32'h0);

    // R11 count write against a same-cycle strobe on channel 1
    bus_wr(12'h014, 32'd100);
    bus_wr(12'h018, 32'd0);
    bus_wr(12'h01C, 32'd0);
    bus_wr(12'h030, 32'h30);
    tick(5);
    bus_rd(12'h010, rd); chk("R7 ch1 after five strobes", rd, 32'd95);
    ext_tick = 1'b1;
    bus_wr(12'h010, 32'd3);
    ext_tick = 1'b0;
    bus_rd(12'h010, rd); chk("R11 write beats step", rd, 32'd3);
    tick(2); chk("R11 no event before zero", {31'h0, irq[1]}, 32'd0);
    tick(1); chk("R10 zero match toggles", {31'h0, irq[1]}, 32'd1);

    // R4 reset in the middle of activity
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 irq cleared", {24'h0, irq}, 32'h0);
    bus_rd(12'h030, rd); chk("R4 ctrl cleared", rd, 32'h0);
    bus_rd(12'h034, rd); chk("R4 spare cleared", rd, 32'h0);
    bus_rd(12'h014, rd); chk("R4 reload cleared", rd, 32'h0);
    bus_rd(12'h05C, rd); chk("R4 match cleared", rd, 32'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule